// File: doc/BRIEF.md
# Video memory masked write controller

This block is the write-side control of a 16-bit multiport video memory, in a form driven by a system clock. It takes four active-low strobes: row, column, write and transfer/output enable. It also takes a function-select line and the 16-bit data bus. Each strobe passes through a synchronizer and then an edge detector. At a row-strobe fall the block classifies the row cycle as one of normal, register-load, transfer or refresh. At the same edge it fixes the per-bit write mask that applies for the whole row.

Inside a normal row, each qualifying strobe edge produces one registered write pulse. The pulse carries a data word and a per-bit write enable for the storage array. Early writes take their data at the column-strobe fall, and late writes, including read-modify-write, take it at the write-strobe fall. A register-load row stores the bus value into a persistent mask register or a color register, and produces no array write. A refresh row, with the column strobe low before the row strobe, discards the persistent mask.

Top module: `vram_wr_ctl`

## Requirements
- R1: Early write: when the write strobe is already low at the column-strobe fall of a normal row, one write is issued, with data equal to the bus value at that column-strobe fall.
- R2: Late write: a column-strobe fall with the write strobe high issues no write. A later write-strobe fall while the column strobe is low issues one write with the bus value at the write-strobe fall, which covers read-modify-write.
- R3: If the write strobe is low at the row-strobe fall, the bus value at that edge becomes the bit mask for every write of that row. If it is high, the mask is all ones.
- R4: `wr_bitmask` bit i is 1 exactly when data bit i is to be written. A 0 bit leaves that array bit unchanged.
- R5: A row that starts with `fsel`=1, column strobe high and transfer strobe high is a register-load row. A capture in it with `fsel`=0 stores the bus value as the persistent mask and marks it valid. A later load replaces it.
- R6: While the persistent mask is valid and the write strobe is low at the row-strobe fall, the bus value at that edge is ignored and the stored mask is used.
- R7: In a register-load row, a capture with `fsel`=1 stores the bus value into the color register. Register-load rows issue no array write.
- R8: In a normal row, a capture with `fsel`=1 is a block/flash write: `wr_blk`=1 and the data is the color register, gated by the row mask as in R3 and R6.
- R9: A row-strobe fall with the column strobe already low is a refresh row. It invalidates the persistent mask and issues no write.
- R10: Reset clears the persistent mask to invalid and the color register to zero, and drives `wr_en`, `wr_blk`, `wr_data` and `wr_bitmask` to zero.
- R11: A row-strobe fall with the transfer/output-enable strobe low starts a transfer row, in which no write is issued.
- R12: Each write is a one-cycle `wr_en` pulse, and `wr_bitmask` is all zero whenever `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Transfer/output-enable strobe, active low |
| fsel | input | 1 | Function select: register choice or block write |
| dq_in | input | 16 | Data bus input |
| wr_en | output | 1 | One-cycle array write pulse |
| wr_blk | output | 1 | Write is a block/flash write using color data |
| wr_data | output | 16 | Data word for the array |
| wr_bitmask | output | 16 | Per-bit write enable for the array |

## Verification
The main function is tried with a table of complete row cycles. The table crosses early against late capture, unmasked rows against rows with a fresh mask, and plain writes against block writes. Each row carries distinct data and mask values, so a swap of the row-fall bus value with the capture-time bus value shows up, and so does a mix-up of the two capture points. Register-load rows are placed between the writes. The following writes then tell a stored mask apart from a fresh one, a replaced mask from the first one, and a cleared mask after refresh from a stale one. Directed rows separate a pure read from read-modify-write and check that two writes in one row share one mask. A mid-run reset checks that the stored color and mask are gone.

// File: rtl/vram_wr_pkg.sv
package vram_wr_pkg;
  typedef enum logic [2:0] {
    ROW_IDLE,
    ROW_NORMAL,
    ROW_LOAD,
    ROW_XFER,
    ROW_REFRESH
  } row_kind_e;
endpackage

// File: rtl/vram_sync.sv
module vram_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/vram_row_ctl.sv
module vram_row_ctl
  import vram_wr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          row_fall,
  input  logic          row_rise,
  input  logic          col_lo,
  input  logic          we_lo,
  input  logic          oe_lo,
  input  logic          fsel,
  input  logic [DW-1:0] dq,
  input  logic          pmask_vld,
  input  logic [DW-1:0] pmask,
  output row_kind_e     kind,
  output logic [DW-1:0] row_mask,
  output logic          cbr_p
);
  assign cbr_p = row_fall & col_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind     <= ROW_IDLE;
      row_mask <= '1;
    end else if (row_fall) begin
      if (col_lo)      kind <= ROW_REFRESH;
      else if (oe_lo)  kind <= ROW_XFER;
      else if (fsel)   kind <= ROW_LOAD;
      else             kind <= ROW_NORMAL;
      if (we_lo) row_mask <= pmask_vld ? pmask : dq;
      else       row_mask <= '1;
    end else if (row_rise) begin
      kind <= ROW_IDLE;
    end
  end
endmodule

// File: rtl/vram_mask_regs.sv
module vram_mask_regs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cbr_p,
  input  logic          ldmask_p,
  input  logic          ldcolor_p,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] pmask,
  output logic          pmask_vld,
  output logic [DW-1:0] color
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pmask     <= '0;
      pmask_vld <= 1'b0;
      color     <= '0;
    end else begin
      if (cbr_p) begin
        pmask_vld <= 1'b0;
      end else if (ldmask_p) begin
        pmask     <= din;
        pmask_vld <= 1'b1;
      end
      if (ldcolor_p) color <= din;
    end
  end
endmodule

// File: rtl/vram_wr_ctl.sv
module vram_wr_ctl
  import vram_wr_pkg::*;
#(
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          row_n,
  input  logic          col_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          fsel,
  input  logic [DW-1:0] dq_in,
  output logic          wr_en,
  output logic          wr_blk,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] wr_bitmask
);
  localparam int NSTB = 5;

  logic [NSTB-1:0] stb_s;
  logic [DW-1:0]   dq_s;
  logic            s_row, s_col, s_we, s_oe, s_fsel;
  logic            p_row, p_col, p_we;
  logic            row_fall, row_rise, col_fall, we_fall;
  logic            cap, wr_p, ldmask_p, ldcolor_p, cbr_p;
  row_kind_e       kind;
  logic [DW-1:0]   row_mask, pmask, color_q;
  logic            pmask_vld;

  vram_sync #(.W(NSTB), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_stb_sync (
    .clk(clk), .rst(rst),
    .din({fsel, oe_n, we_n, col_n, row_n}),
    .dout(stb_s)
  );

  vram_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dq_sync (
    .clk(clk), .rst(rst), .din(dq_in), .dout(dq_s)
  );

  assign {s_fsel, s_oe, s_we, s_col, s_row} = stb_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_row <= 1'b1;
      p_col <= 1'b1;
      p_we  <= 1'b1;
    end else begin
      p_row <= s_row;
      p_col <= s_col;
      p_we  <= s_we;
    end
  end

  assign row_fall = p_row & ~s_row;
  assign row_rise = ~p_row & s_row;
  assign col_fall = p_col & ~s_col;
  assign we_fall  = p_we & ~s_we;

  // early capture at column fall, late capture at write fall with column low
  assign cap       = (col_fall & ~s_we) | (we_fall & ~s_col & ~col_fall);
  assign wr_p      = cap & (kind == ROW_NORMAL);
  assign ldmask_p  = cap & (kind == ROW_LOAD) & ~s_fsel;
  assign ldcolor_p = cap & (kind == ROW_LOAD) & s_fsel;

  vram_row_ctl #(.DW(DW)) u_row (
    .clk(clk), .rst(rst),
    .row_fall(row_fall), .row_rise(row_rise),
    .col_lo(~s_col), .we_lo(~s_we), .oe_lo(~s_oe), .fsel(s_fsel),
    .dq(dq_s), .pmask_vld(pmask_vld), .pmask(pmask),
    .kind(kind), .row_mask(row_mask), .cbr_p(cbr_p)
  );

  vram_mask_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .cbr_p(cbr_p), .ldmask_p(ldmask_p), .ldcolor_p(ldcolor_p),
    .din(dq_s),
    .pmask(pmask), .pmask_vld(pmask_vld), .color(color_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en      <= 1'b0;
      wr_blk     <= 1'b0;
      wr_data    <= '0;
      wr_bitmask <= '0;
    end else begin
      wr_en      <= wr_p;
      wr_blk     <= wr_p & s_fsel;
      wr_data    <= wr_p ? (s_fsel ? color_q : dq_s) : '0;
      wr_bitmask <= wr_p ? row_mask : '0;
    end
  end
endmodule

// File: rtl/vram_wr_ctl_chk.sv
module vram_wr_ctl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          wr_blk,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] wr_bitmask,
  input logic [DW-1:0] color_q,
  input logic          pmask_vld,
  input logic          cbr_p,
  input logic          ldmask_p
);
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  a_r12_idle_mask: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (wr_bitmask == '0));

  a_r9_refresh_clears: assert property (@(posedge clk) disable iff (rst)
    cbr_p |=> !pmask_vld);

  a_r5_load_sets_valid: assert property (@(posedge clk) disable iff (rst)
    ldmask_p |=> pmask_vld);

  a_r8_block_color: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_blk) |-> (wr_data == color_q));

  a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pmask_vld && color_q == '0 && !wr_en));
endmodule

bind vram_wr_ctl vram_wr_ctl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_blk(wr_blk),
  .wr_data(wr_data), .wr_bitmask(wr_bitmask), .color_q(color_q),
  .pmask_vld(pmask_vld), .cbr_p(cbr_p), .ldmask_p(ldmask_p)
);

// File: tb/vram_wr_ctl_bench.sv
module vram_wr_ctl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        row_n = 1'b1, col_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, fsel = 1'b0;
  logic [15:0] dq_in = '0;
  logic        wr_en, wr_blk;
  logic [15:0] wr_data, wr_bitmask;

  int nchk = 0, nfail = 0;
  int nwr = 0, run = 0, maxrun = 0, idle_bad = 0;
  logic [15:0] last_d = '0, last_m = '0;
  logic        last_b = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  vram_wr_ctl u_vram_wr_ctl (
    .clk(clk), .rst(rst), .row_n(row_n), .col_n(col_n), .we_n(we_n),
    .oe_n(oe_n), .fsel(fsel), .dq_in(dq_in), .wr_en(wr_en),
    .wr_blk(wr_blk), .wr_data(wr_data), .wr_bitmask(wr_bitmask)
  );

  always @(negedge clk) begin
    if (!rst && wr_en) begin
      nwr++;
      run++;
      if (run > maxrun) maxrun = run;
      last_d = wr_data;
      last_m = wr_bitmask;
      last_b = wr_blk;
    end else begin
      run = 0;
      if (!rst && wr_bitmask != 16'h0) idle_bad++;
    end
  end

  typedef struct packed {
    logic [1:0]  kind;   // 0 normal, 1 transfer, 2 refresh
    logic        fr;     // fsel at row fall
    logic        wr;     // write strobe low at row fall
    logic        late;
    logic        fc;     // fsel at capture
    logic [15:0] dr;     // bus at row fall
    logic [15:0] dw;     // bus at capture
    logic [1:0]  ncnt;
    logic [15:0] ed;
    logic [15:0] em;
    logic        eb;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{2'd0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'hA5A5,2'd1,16'hA5A5,16'hFFFF,1'b0}, // R1
    '{2'd0,1'b0,1'b0,1'b1,1'b0,16'h0000,16'h1234,2'd1,16'h1234,16'hFFFF,1'b0}, // R2
    '{2'd0,1'b0,1'b1,1'b0,1'b0,16'h00FF,16'hBEEF,2'd1,16'hBEEF,16'h00FF,1'b0}, // R3
    '{2'd0,1'b0,1'b1,1'b1,1'b0,16'hF0F0,16'h5555,2'd1,16'h5555,16'hF0F0,1'b0}, // R4
    '{2'd0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'hFFFF,2'd1,16'h0000,16'hFFFF,1'b1}, // R10 color zero
    '{2'd0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'hC3C3,2'd0,16'h0000,16'h0000,1'b0}, // R7
    '{2'd0,1'b0,1'b1,1'b0,1'b1,16'h0F0F,16'h1111,2'd1,16'hC3C3,16'h0F0F,1'b1}, // R8
    '{2'd0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h3C00,2'd0,16'h0000,16'h0000,1'b0}, // R5
    '{2'd0,1'b0,1'b1,1'b0,1'b0,16'hFFFF,16'h7777,2'd1,16'h7777,16'h3C00,1'b0}, // R6
    '{2'd0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h8888,2'd1,16'h8888,16'hFFFF,1'b0}, // R3
    '{2'd0,1'b0,1'b1,1'b1,1'b1,16'h0001,16'h2222,2'd1,16'hC3C3,16'h3C00,1'b1}, // R6
    '{2'd0,1'b1,1'b0,1'b1,1'b0,16'h0000,16'h0081,2'd0,16'h0000,16'h0000,1'b0}, // R5
    '{2'd0,1'b0,1'b1,1'b1,1'b0,16'hFFFF,16'h4242,2'd1,16'h4242,16'h0081,1'b0}, // R5
    '{2'd1,1'b0,1'b1,1'b0,1'b0,16'hFFFF,16'h6666,2'd0,16'h0000,16'h0000,1'b0}, // R11
    '{2'd2,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,2'd0,16'h0000,16'h0000,1'b0}, // R9
    '{2'd0,1'b0,1'b1,1'b0,1'b0,16'h00F0,16'h9999,2'd1,16'h9999,16'h00F0,1'b0}  // R9
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic row_open(input bit fr, input bit wr, input bit oe, input logic [15:0] dr);
    fsel = fr; we_n = ~wr; oe_n = ~oe; dq_in = dr; col_n = 1'b1;
    step(4);
    row_n = 1'b0;
    step(4);
    we_n = 1'b1; oe_n = 1'b1;
    step(4);
  endtask

  task automatic col_write(input bit late, input bit fc, input logic [15:0] dw);
    fsel = fc; dq_in = dw;
    if (!late) begin
      we_n = 1'b0; step(4); col_n = 1'b0; step(4);
    end else begin
      col_n = 1'b0; step(4); we_n = 1'b0; step(4);
    end
    col_n = 1'b1; we_n = 1'b1;
    step(4);
  endtask

  task automatic row_close();
    row_n = 1'b1; fsel = 1'b0;
    step(6);
  endtask

  task automatic refresh_row();
    col_n = 1'b0; step(4);
    row_n = 1'b0; step(4);
    col_n = 1'b1; row_n = 1'b1;
    step(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int base;
    step(4);
    rst = 1'b0;
    step(2);
    // R10 reset state
    chk(wr_en == 1'b0 && wr_blk == 1'b0, "R10 ctl after reset", {30'd0, wr_en, wr_blk}, 32'd0);
    chk(wr_data == 16'h0 && wr_bitmask == 16'h0, "R10 data after reset", {wr_data, wr_bitmask}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      base = nwr;
      if (TBL[i].kind == 2'd2) begin
        refresh_row();
      end else begin
        row_open(TBL[i].fr, TBL[i].wr, TBL[i].kind == 2'd1, TBL[i].dr);
        col_write(TBL[i].late, TBL[i].fc, TBL[i].dw);
        row_close();
      end
      chk(nwr - base == int'(TBL[i].ncnt), $sformatf("R1-table row %0d write count", i),
          32'(nwr - base), 32'(TBL[i].ncnt));
      if (TBL[i].ncnt != 2'd0) begin
        chk(last_d == TBL[i].ed, $sformatf("table row %0d data", i), 32'(last_d), 32'(TBL[i].ed));
        chk(last_m == TBL[i].em, $sformatf("R4 table row %0d mask", i), 32'(last_m), 32'(TBL[i].em));
        chk(last_b == TBL[i].eb, $sformatf("R8 table row %0d blk", i), 32'(last_b), 32'(TBL[i].eb));
      end
    end

    // R2: pure read row issues no write
    base = nwr;
    row_open(1'b0, 1'b0, 1'b0, 16'h0);
    dq_in = 16'hDEAD; col_n = 1'b0; step(6); col_n = 1'b1; step(4);
    row_close();
    chk(nwr == base, "R2 read row no write", 32'(nwr - base), 32'd0);

    // R2: read-modify-write, capture on write-strobe fall
    base = nwr;
    row_open(1'b0, 1'b1, 1'b0, 16'h0C0C);
    dq_in = 16'h1111; col_n = 1'b0; step(6);
    dq_in = 16'hABCD; step(4); we_n = 1'b0; step(4);
    we_n = 1'b1; col_n = 1'b1; step(4);
    row_close();
    chk(nwr - base == 1, "R2 rmw count", 32'(nwr - base), 32'd1);
    chk(last_d == 16'hABCD, "R2 rmw data", 32'(last_d), 32'hABCD);
    chk(last_m == 16'h0C0C, "R3 rmw mask", 32'(last_m), 32'h0C0C);

    // R3: two writes in one row share the row mask
    base = nwr;
    row_open(1'b0, 1'b1, 1'b0, 16'h0300);
    col_write(1'b0, 1'b0, 16'h0101);
    chk(last_m == 16'h0300, "R3 first write mask", 32'(last_m), 32'h0300);
    col_write(1'b1, 1'b0, 16'h0202);
    row_close();
    chk(nwr - base == 2, "R3 two writes", 32'(nwr - base), 32'd2);
    chk(last_d == 16'h0202 && last_m == 16'h0300, "R3 second write", {last_d, last_m}, 32'h02020300);

    // R12 pulse shape
    chk(maxrun == 1, "R12 pulse width", 32'(maxrun), 32'd1);
    chk(idle_bad == 0, "R12 idle mask zero", 32'(idle_bad), 32'd0);

    // R10 mid-run reset drops stored color and mask
    row_open(1'b1, 1'b0, 1'b0, 16'h0); col_write(1'b0, 1'b1, 16'h7E7E); row_close();
    row_open(1'b1, 1'b0, 1'b0, 16'h0); col_write(1'b0, 1'b0, 16'h000F); row_close();
    rst = 1'b1; step(3); rst = 1'b0; step(2);
    chk(wr_en == 1'b0 && wr_bitmask == 16'h0, "R10 outputs after mid reset", {15'd0, wr_en, wr_bitmask}, 32'd0);
    row_open(1'b0, 1'b1, 1'b0, 16'h5000);
    col_write(1'b0, 1'b1, 16'hFFFF);
    row_close();
    chk(last_d == 16'h0000, "R10 color cleared", 32'(last_d), 32'h0);
    chk(last_m == 16'h5000, "R10 stored mask cleared", 32'(last_m), 32'h5000);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule